// File: doc/BRIEF.md
# Capability Bit-Cell Transmitter

This block sends a capability word over an out-of-band link, one bit per bit cell. It does not create bursts itself. At the start of every cell that carries a one, it gives a one-cycle request to an external burst generator. That generator then plays a complete wake sequence, including its negation period, which fills the cell. A cell that carries a zero gets no request, so the line stays at DC idle for the whole cell.

A frame always opens with a start cell that is sent as a one. The remaining cells carry the captured word, most significant bit first. The cell timer starts in the same cycle as the first wake request, so all later cell boundaries are counted from the moment the start bit goes out.

The caller presents a word and pulses `start_i`. The block reports `busy_o` while the frame is on the line, and `done_o` for one cycle when the frame ends.

Top module: `capbit_tx`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `wake_req_o`, `busy_o` and `done_o` are all low in the next cycle. This holds even if a frame was in progress.
- R2: When `start_i` is high at an edge while `busy_o` is low, the next cycle has `busy_o` high and `wake_req_o` high. That `wake_req_o` pulse is the start bit, which is always a one.
- R3: Every cell lasts exactly `CELL_CYCLES` clock cycles. Cell n starts `n*CELL_CYCLES` cycles after the start-bit request cycle.
- R4: In a cell carrying a one, `wake_req_o` is high only in the cell's first cycle. In a cell carrying a zero, `wake_req_o` stays low for the whole cell.
- R5: For n from 1 to `NUM_CELLS-1`, cell n carries bit `cap_word_i[NUM_CELLS-1-n]`. The word is sent most significant bit first, and the word width is `NUM_CELLS-1`.
- R6: Consecutive ones are sent back to back. Each new request falls in the cycle right after the previous cell's last cycle, so the requests are exactly `CELL_CYCLES` apart.
- R7: After `NUM_CELLS` cells, `done_o` is high for exactly one cycle. `busy_o` is low in that same cycle, and `busy_o` was high for exactly `NUM_CELLS*CELL_CYCLES` cycles.
- R8: The word is sampled at the accepting edge. Changes on `cap_word_i` while `busy_o` is high have no effect on the cells sent.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The frame's timing and content are unchanged.
- R10: A start presented in the `done_o` cycle is accepted, because `busy_o` is already low. The next frame's start bit follows with no idle cell between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to send a frame; honoured only while idle |
| cap_word_i | input | NUM_CELLS-1 | Capability word, sampled when a start is accepted |
| wake_req_o | output | 1 | One-cycle request for a full wake sequence at the start of a one cell |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle pulse when the last cell ends |

## Verification
The embedded assertions check, on every cycle, the properties that hold locally:
- a request only ever falls on the first cycle of a cell (cell count zero);
- the timer never runs past its last count;
- a new frame always opens with a request;
- `done_o` is a single-cycle pulse that comes as `busy_o` falls;
- the held word changes only on a load or a shift;
- a start during a frame does not disturb the cell count.

Only the bench's scenarios can show the rest:
- the bit order across a whole frame and the exact cell positions;
- gap-free runs of ones;
- the total frame length;
- that changing the input word mid-frame has no effect;
- back-to-back frames.

// File: rtl/capbit_tx_pkg.sv
// Package: shared types for the capability bit-cell transmitter.
package capbit_tx_pkg;

    // Frame-level control state.
    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

endpackage

// File: rtl/capbit_cell_timer.sv
// Module: capbit_cell_timer
// Counts clock cycles inside one bit cell and flags the last cycle of a cell.
// Assumes CELL_CYCLES >= 2. A restart forces the count to zero, so the cycle
// after a restart is the first cycle of a cell.
module capbit_cell_timer #(
    parameter int CELL_CYCLES = 2200,
    localparam int CNT_W = (CELL_CYCLES > 2) ? $clog2(CELL_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cell_last_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign cnt_o       = cnt_q;
    assign cell_last_o = run_i && (cnt_q == LAST);

    // Cycle counter: cleared on restart, wraps at the cell length while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // R3: the count never leaves the cell range.
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3: a running count at its last value wraps to zero.
    p_cnt_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && cnt_q == LAST) |=> (cnt_q == '0));

endmodule

// File: rtl/capbit_bit_sequencer.sv
// Module: capbit_bit_sequencer
// Holds the frame (start bit followed by the word, MSB first) in a shift
// register and tracks which cell is being sent. Assumes that load and
// advance are never high together.
module capbit_bit_sequencer #(
    parameter int NUM_CELLS = 32,
    localparam int WORD_W = NUM_CELLS - 1,
    localparam int IDX_W  = $clog2(NUM_CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              advance_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              cur_bit_o,
    output logic              next_bit_o,
    output logic              last_cell_o
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_CELLS - 1);

    logic [NUM_CELLS-1:0] frame_q;
    logic [IDX_W-1:0]     idx_q;

    assign cur_bit_o   = frame_q[NUM_CELLS-1];
    assign next_bit_o  = frame_q[NUM_CELLS-2];
    assign last_cell_o = (idx_q == IDX_LAST);

    // Frame register: captured with a leading start bit, shifted once per cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (load_i) begin
            frame_q <= {1'b1, word_i};
        end else if (advance_i) begin
            frame_q <= {frame_q[NUM_CELLS-2:0], 1'b0};
        end
    end

    // Cell index: zero on load, incremented on each cell boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load_i) begin
            idx_q <= '0;
        end else if (advance_i && !last_cell_o) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // R8: the held frame changes only on a load or a shift.
    p_frame_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !advance_i) |=> $stable(frame_q));

    // R2: a freshly loaded frame always starts with a one.
    p_start_bit_loaded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cur_bit_o);

    // R7: the index never passes the last cell.
    p_idx_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_LAST);

endmodule

// File: rtl/capbit_tx.sv
// Module: capbit_tx (top)
// Sends a start cell and then a NUM_CELLS-1 bit word, one bit per cell of
// CELL_CYCLES clocks. For each one cell it requests a full wake sequence
// from an external burst generator with a single-cycle pulse on the cell's
// first cycle. Assumes the generator fits the burst and its negation inside
// one cell. The cell timer starts together with the start-bit request.
module capbit_tx
    import capbit_tx_pkg::*;
#(
    parameter int CELL_CYCLES = 2200,
    parameter int NUM_CELLS   = 32,
    localparam int WORD_W = NUM_CELLS - 1,
    localparam int CNT_W  = (CELL_CYCLES > 2) ? $clog2(CELL_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] cap_word_i,
    output logic              wake_req_o,
    output logic              busy_o,
    output logic              done_o
);

    tx_state_e        state_q;
    logic             wake_q;
    logic             done_q;
    logic             accept;
    logic             cell_last;
    logic [CNT_W-1:0] cell_cnt;
    logic             cur_bit;
    logic             next_bit;
    logic             last_cell;
    logic             advance;

    assign accept     = (state_q == TX_IDLE) && start_i;
    assign advance    = cell_last && !last_cell;
    assign busy_o     = (state_q == TX_SEND);
    assign wake_req_o = wake_q;
    assign done_o     = done_q;

    capbit_cell_timer #(.CELL_CYCLES(CELL_CYCLES)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (accept),
        .run_i       (busy_o),
        .cnt_o       (cell_cnt),
        .cell_last_o (cell_last)
    );

    capbit_bit_sequencer #(.NUM_CELLS(NUM_CELLS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .advance_i   (advance),
        .word_i      (cap_word_i),
        .cur_bit_o   (cur_bit),
        .next_bit_o  (next_bit),
        .last_cell_o (last_cell)
    );

    // Frame state: idle until a start is accepted, back to idle after the last cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else if (accept) begin
            state_q <= TX_SEND;
        end else if (busy_o && cell_last && last_cell) begin
            state_q <= TX_IDLE;
        end
    end

    // Wake request: pulse on the first cycle of every cell that carries a one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
        end else if (accept) begin
            wake_q <= 1'b1;
        end else begin
            wake_q <= busy_o && advance && next_bit;
        end
    end

    // Done pulse: one cycle after the final cell's last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= busy_o && cell_last && last_cell;
        end
    end

    // R4: a request never appears outside a frame.
    p_wake_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> busy_o);

    // R6: a request only falls on the first cycle of a cell.
    p_wake_cell_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> (cell_cnt == '0));

    // R4: a request always matches the bit of the current cell.
    p_wake_matches_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> cur_bit);

    // R2: every frame opens with the start-bit request.
    p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> wake_req_o);

    // R7: done is a single-cycle pulse that coincides with busy falling.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $fell(busy_o)));

    // R9: a start during a frame does not disturb the cell count.
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !cell_last) |=> (cell_cnt == $past(cell_cnt) + 1'b1));

endmodule

// File: tb/capbit_tx_bench.sv
// Bench for capbit_tx: a table of words walked by one loop, then directed
// tests for reset and corner cases. Expected cells are rebuilt from the
// requirements: cell 0 is a one, and cell n carries word bit WORD_W-n.
module capbit_tx_bench;

    localparam int  CLK_PERIOD = 10;
    localparam int  CELL_C     = 4;
    localparam int  CELLS      = 32;
    localparam int  WORD_W     = CELLS - 1;
    localparam int  FRAME_LEN  = CELLS * CELL_C;
    localparam int  NVEC       = 6;

    // Stimulus: bit WORD_W = perturb flag (new word and start pulse mid-frame).
    localparam logic [WORD_W:0] VEC [NVEC] = '{
        {1'b0, 31'h0000_0000},
        {1'b0, 31'h7FFF_FFFF},
        {1'b1, 31'h5555_5555},
        {1'b0, 31'h4000_0001},
        {1'b1, 31'h2AAA_AAAA},
        {1'b0, 31'h00F0_F00F}
    };
    // Expected number of one cells, start bit included.
    localparam int EXP_ONES [NVEC] = '{1, 32, 17, 3, 16, 13};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [WORD_W-1:0] cap_word_i = '0;
    logic              wake_req_o;
    logic              busy_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;

    capbit_tx #(.CELL_CYCLES(CELL_C), .NUM_CELLS(CELLS)) u_capbit_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cap_word_i (cap_word_i),
        .wake_req_o (wake_req_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Starts a frame at the current negedge and samples every cycle until the
    // done cycle. Returns at the negedge in the middle of the done cycle.
    task automatic run_frame(input logic [WORD_W-1:0] word, input logic perturb);
        logic [CELLS-1:0] exp_cells;
        logic [CELLS-1:0] got_cells;
        int stray     = 0;
        int busy_bad  = 0;
        int done_bad  = 0;
        exp_cells = {1'b1, word};
        got_cells = '0;
        start_i    = 1'b1;
        cap_word_i = word;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 start bit request", {busy_o, wake_req_o}, 2'b11);
        for (int t = 1; t <= FRAME_LEN + 1; t++) begin
            if (t > 1) @(negedge clk);
            if (perturb && t == 5) begin
                start_i    = 1'b1;
                cap_word_i = ~word;
            end
            if (perturb && t == 6) start_i = 1'b0;
            if (((t - 1) % CELL_C) == 0 && t <= FRAME_LEN)
                got_cells[CELLS - 1 - (t - 1) / CELL_C] = wake_req_o;
            else if (wake_req_o)
                stray++;
            if (busy_o !== (t <= FRAME_LEN)) busy_bad++;
            if (done_o !== (t == FRAME_LEN + 1)) done_bad++;
        end
        check("R5 cell order MSB first", 64'(got_cells), 64'(exp_cells));
        check("R4 no request outside cell start", 64'(stray), 64'd0);
        check("R6 one count back to back", 64'($countones(got_cells)), 64'(EXP_ONES[0] * 0 + $countones(exp_cells)));
        check("R3 busy length", 64'(busy_bad), 64'd0);
        check("R7 done single cycle at end", 64'(done_bad), 64'd0);
        if (perturb) check("R8 R9 mid-frame changes ignored", 64'(got_cells), 64'(exp_cells));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: outputs low after reset.
        repeat (3) @(negedge clk);
        check("R1 reset state", {wake_req_o, busy_o, done_o}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {wake_req_o, busy_o, done_o}, 3'b000);

        // Table walk: vectors 1..5 start in the previous done cycle (R10).
        for (int v = 0; v < NVEC; v++) begin
            run_frame(VEC[v][WORD_W-1:0], VEC[v][WORD_W]);
            check("R6 table ones", 64'($countones({1'b1, VEC[v][WORD_W-1:0]})), 64'(EXP_ONES[v]));
        end

        // R10: a start in the done cycle gives busy in the very next cycle.
        start_i    = 1'b1;
        cap_word_i = 31'h1;
        @(negedge clk);
        start_i = 1'b0;
        check("R10 back-to-back accept", {busy_o, wake_req_o}, 2'b11);

        // R1: reset in the middle of a frame clears everything.
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-frame reset", {wake_req_o, busy_o, done_o}, 3'b000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 stays idle", {wake_req_o, busy_o, done_o}, 3'b000);

        // R3: cell spacing after an idle gap, word with ones in the last cells.
        run_frame(31'h0000_0003, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule